// File: doc/BRIEF.md
# Ring Buffer Pointer Sequencer

This block keeps the pointers for a set of ring buffers in system memory that feed a signal processor's streaming ports. Every ring has a lower bound, an upper bound and a running pointer, and all three sit in registers on a simple register bus. There are two groups of rings. Write rings carry data from the processor to memory, and read rings carry data from memory to the processor. The two groups have different sizes but use the same register layout.

A client asks for a transfer by giving a direction, a ring index and a byte count. The block clamps the running pointer up to the lower bound. It then splits the transfer into linear memory bursts, and no burst crosses the upper bound. After each burst the pointer advances, and when it lands exactly on the upper bound it returns to the lower bound. When the transfer completes, the final pointer is stored back into the ring's register. A ring whose pointer is already at or beyond its upper bound is not served: the block sets a sticky hang flag for it instead. Address translation and the data movement are handled outside this block.

Top module: `ring_ptr_unit`

## Requirements
- R1: After reset every ring register and the status register read zero, `req_ready_o` is high and `mem_req_o` is low.
- R2: The registers of write ring n sit at byte offset 0x24+0x10·n and those of read ring n at 0x64+0x10·n. Within a group, +0 is the lower bound, +4 the upper bound and +8 the pointer. The bounds keep only bits 23:8 and the pointer keeps only bits 23:2. All other bits read as zero.
- R3: With `req_dir_i`=1 the index selects a write ring and bursts carry `mem_we_o`=1. With `req_dir_i`=0 it selects a read ring and bursts carry `mem_we_o`=0.
- R4: A pointer below the lower bound is treated as equal to the lower bound when a transfer starts.
- R5: If the clamped pointer is at or above the upper bound, no burst is issued and no `done_o` pulse follows. Instead status bit n is set for write ring n, or bit 4+n for read ring n. The status register is at offset 0x00.
- R6: Each burst starts at the current pointer. Its length is the smaller of (upper bound − pointer) and the bytes still to move, and it is never zero.
- R7: A pointer that reaches the upper bound exactly after a burst continues from the lower bound.
- R8: When all bytes have been moved, the final pointer is written into the ring's pointer register and `done_o` pulses for exactly one cycle.
- R9: A zero-byte request issues no burst, still pulses `done_o`, and stores the clamped pointer.
- R10: While a ring has a transfer in flight, a register write to that ring holds `reg_wready_o` low and takes effect only after the transfer completes. Writes to other rings proceed at once.
- R11: `mem_req_o`, `mem_addr_o`, `mem_len_o` and `mem_we_o` stay constant until the cycle in which `mem_ack_i` is high.
- R12: Only one request is handled at a time, and `req_ready_o` is low from acceptance until the transfer ends.
- R13: Writing 1 to a status bit clears it. Bits written with 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_wready_o | output | 1 | Write accepted at this edge when high |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| req_valid_i | input | 1 | Transfer request valid |
| req_ready_o | output | 1 | Block can take a request |
| req_dir_i | input | 1 | 1 = write ring, 0 = read ring |
| req_chan_i | input | 2 | Ring index within the selected group |
| req_len_i | input | 16 | Byte count |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Burst request |
| mem_we_o | output | 1 | Burst direction, 1 = write to memory |
| mem_addr_o | output | 24 | Burst start address |
| mem_len_o | output | 16 | Burst length in bytes |
| mem_ack_i | input | 1 | Burst accepted |

## Verification
The bench uses the default parameters: four write rings, two read rings, 24-bit pointers and 16-bit byte counts. Because the counts reach well beyond a 256-byte ring, a single request can wrap several times, and each wrap is split and checked against the scoreboard. The unequal group sizes put the read rings at the upper status bits and at the second register window, so any mixing up of the groups shows up in the status and pointer values. A slow acknowledge keeps one ring busy long enough to check that writes to it are held off while writes to another ring go through.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_BURST} seq_st_e;
endpackage

// File: rtl/ring_regfile.sv
module ring_regfile #(
  parameter int N_WR     = 4,
  parameter int N_RD     = 2,
  parameter int ADDR_W   = 24,
  parameter int DW       = 32,
  parameter int RA_W     = 8,
  parameter int BND_LSB  = 8,
  parameter int PTR_LSB  = 2,
  parameter int WR_OFS   = 'h24,
  parameter int RD_OFS   = 'h64,
  parameter int STRIDE   = 'h10,
  parameter int STAT_OFS = 'h00,
  localparam int NCH  = N_WR + N_RD,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic              reg_wready_o,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              busy_i,
  input  logic [CH_W-1:0]   sel_ch_i,
  output logic [ADDR_W-1:0] sel_base_o,
  output logic [ADDR_W-1:0] sel_end_o,
  output logic [ADDR_W-1:0] sel_cur_o,
  input  logic              wb_en_i,
  input  logic [ADDR_W-1:0] wb_val_i,
  input  logic              hang_set_i
);
  localparam logic [DW-1:0] VAL_MASK = DW'({ADDR_W{1'b1}});
  localparam logic [DW-1:0] BND_MASK = VAL_MASK & ~((DW'(1) << BND_LSB) - DW'(1));
  localparam logic [DW-1:0] PTR_MASK = VAL_MASK & ~((DW'(1) << PTR_LSB) - DW'(1));

  logic [DW-1:0]  base_q [NCH];
  logic [DW-1:0]  end_q  [NCH];
  logic [DW-1:0]  cur_q  [NCH];
  logic [NCH-1:0] hit_b, hit_e, hit_c, chan_hit;
  logic [NCH-1:0] stat_q, stat_set, stat_clr;
  logic           hit_stat, wr_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    localparam int OFS = (c < N_WR) ? WR_OFS + STRIDE * c : RD_OFS + STRIDE * (c - N_WR);
    assign hit_b[c] = (reg_addr_i == RA_W'(OFS));
    assign hit_e[c] = (reg_addr_i == RA_W'(OFS + 4));
    assign hit_c[c] = (reg_addr_i == RA_W'(OFS + 8));
  end

  assign chan_hit     = hit_b | hit_e | hit_c;
  assign hit_stat     = (reg_addr_i == RA_W'(STAT_OFS));
  // hold off writes aimed at the ring in flight
  assign reg_wready_o = !(reg_we_i && busy_i && chan_hit[sel_ch_i]);
  assign wr_ok        = reg_we_i && reg_wready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        base_q[c] <= '0;
        end_q[c]  <= '0;
        cur_q[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_ok && hit_b[c]) base_q[c] <= reg_wdata_i & BND_MASK;
        if (wr_ok && hit_e[c]) end_q[c]  <= reg_wdata_i & BND_MASK;
        if (wb_en_i && sel_ch_i == CH_W'(c)) cur_q[c] <= DW'(wb_val_i) & PTR_MASK;
        else if (wr_ok && hit_c[c])          cur_q[c] <= reg_wdata_i & PTR_MASK;
      end
    end
  end

  assign stat_set = hang_set_i ? (NCH'(1) << sel_ch_i) : '0;
  assign stat_clr = (wr_ok && hit_stat) ? reg_wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr) | stat_set;
  end

  always_comb begin
    reg_rdata_o = hit_stat ? DW'(stat_q) : '0;
    for (int c = 0; c < NCH; c++) begin
      if (hit_b[c]) reg_rdata_o = reg_rdata_o | base_q[c];
      if (hit_e[c]) reg_rdata_o = reg_rdata_o | end_q[c];
      if (hit_c[c]) reg_rdata_o = reg_rdata_o | cur_q[c];
    end
  end

  assign sel_base_o = base_q[sel_ch_i][ADDR_W-1:0];
  assign sel_end_o  = end_q[sel_ch_i][ADDR_W-1:0];
  assign sel_cur_o  = cur_q[sel_ch_i][ADDR_W-1:0];
endmodule

// File: rtl/ring_seq.sv
module ring_seq
  import ring_pkg::*;
#(
  parameter int N_WR   = 4,
  parameter int N_RD   = 2,
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  localparam int NCH   = N_WR + N_RD,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MAXN  = (N_WR > N_RD) ? N_WR : N_RD,
  localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_dir_i,
  input  logic [IDX_W-1:0]  req_chan_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic [CH_W-1:0]   sel_ch_o,
  input  logic [ADDR_W-1:0] sel_base_i,
  input  logic [ADDR_W-1:0] sel_end_i,
  input  logic [ADDR_W-1:0] sel_cur_i,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_val_o,
  output logic              hang_set_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  input  logic              mem_ack_i
);
  seq_st_e            st_q;
  logic [CH_W-1:0]    ch_q;
  logic               dir_q, done_q;
  logic [LEN_W-1:0]   rem_q, blen;
  logic [ADDR_W-1:0]  ptr_q, span, nxt, nxt_w, eff;
  logic               last_burst;

  always_comb begin
    eff        = (sel_cur_i < sel_base_i) ? sel_base_i : sel_cur_i;
    span       = sel_end_i - ptr_q;
    blen       = (span < ADDR_W'(rem_q)) ? LEN_W'(span) : rem_q;
    nxt        = ptr_q + ADDR_W'(blen);
    nxt_w      = (nxt == sel_end_i) ? sel_base_i : nxt;
    last_burst = (rem_q == blen);
  end

  always_comb begin
    wb_en_o    = 1'b0;
    wb_val_o   = nxt_w;
    hang_set_o = 1'b0;
    if (st_q == ST_CHECK) begin
      hang_set_o = (eff >= sel_end_i);
      wb_en_o    = (eff < sel_end_i) && (rem_q == '0);
      wb_val_o   = eff;
    end else if (st_q == ST_BURST) begin
      wb_en_o    = mem_ack_i && last_burst;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      dir_q  <= 1'b0;
      rem_q  <= '0;
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wb_en_o;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          ch_q  <= req_dir_i ? CH_W'(req_chan_i) : CH_W'(N_WR) + CH_W'(req_chan_i);
          dir_q <= req_dir_i;
          rem_q <= req_len_i;
          st_q  <= ST_CHECK;
        end
        ST_CHECK: begin
          ptr_q <= eff;
          if (eff >= sel_end_i || rem_q == '0) st_q <= ST_IDLE;
          else                                  st_q <= ST_BURST;
        end
        ST_BURST: if (mem_ack_i) begin
          ptr_q <= nxt_w;
          rem_q <= rem_q - blen;
          if (last_burst) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign sel_ch_o    = ch_q;
  assign done_o      = done_q;
  assign mem_req_o   = (st_q == ST_BURST);
  assign mem_we_o    = dir_q;
  assign mem_addr_o  = ptr_q;
  assign mem_len_o   = blen;
endmodule

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit #(
  parameter int N_WR   = 4,
  parameter int N_RD   = 2,
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int DW     = 32,
  parameter int RA_W   = 8,
  localparam int NCH   = N_WR + N_RD,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MAXN  = (N_WR > N_RD) ? N_WR : N_RD,
  localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic              reg_wready_o,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_dir_i,
  input  logic [IDX_W-1:0]  req_chan_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  input  logic              mem_ack_i
);
  logic [CH_W-1:0]   sel_ch;
  logic [ADDR_W-1:0] sel_base, sel_end, sel_cur, wb_val;
  logic              wb_en, hang_set, busy;

  ring_regfile #(
    .N_WR(N_WR), .N_RD(N_RD), .ADDR_W(ADDR_W), .DW(DW), .RA_W(RA_W)
  ) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_wready_o, .reg_rdata_o,
    .busy_i(busy), .sel_ch_i(sel_ch), .sel_base_o(sel_base), .sel_end_o(sel_end),
    .sel_cur_o(sel_cur), .wb_en_i(wb_en), .wb_val_i(wb_val), .hang_set_i(hang_set)
  );

  ring_seq #(
    .N_WR(N_WR), .N_RD(N_RD), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_dir_i, .req_chan_i, .req_len_i,
    .sel_ch_o(sel_ch), .sel_base_i(sel_base), .sel_end_i(sel_end), .sel_cur_i(sel_cur),
    .wb_en_o(wb_en), .wb_val_o(wb_val), .hang_set_o(hang_set), .busy_o(busy),
    .done_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_len_o, .mem_ack_i
  );
endmodule

// File: rtl/ring_ptr_chk.sv
module ring_ptr_chk #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LEN_W-1:0]  mem_len_o,
  input logic              mem_ack_i
);
  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_len_o) && $stable(mem_we_o));
  // R6
  burst_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_len_o != '0);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R12
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  // R12
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

bind ring_ptr_unit ring_ptr_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .done_o,
  .mem_req_o, .mem_we_o, .mem_addr_o, .mem_len_o, .mem_ack_i
);

// File: tb/tb_ring_ptr_unit.sv
module tb_ring_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wready;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0, req_ready, req_dir = 1'b0;
  logic [1:0]  req_chan = '0;
  logic [15:0] req_len = '0;
  logic        done, mem_req, mem_we, mem_ack = 1'b0;
  logic [23:0] mem_addr;
  logic [15:0] mem_len;

  always #2.5 clk = ~clk;

  ring_ptr_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_wready_o(reg_wready), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_dir_i(req_dir),
    .req_chan_i(req_chan), .req_len_i(req_len), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_len_o(mem_len), .mem_ack_i(mem_ack)
  );

  typedef struct { logic [23:0] a; logic [15:0] l; logic w; } burst_t;
  burst_t exp_q[$];
  int n_cmp = 0, n_bad = 0, done_cnt = 0, ack_dly = 1;
  logic [23:0] m_base[6], m_end[6], m_cur[6];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [7:0] ofs(int g);
    return (g < 4) ? 8'(8'h24 + 16 * g) : 8'(8'h64 + 16 * (g - 4));
  endfunction

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    #1;
    while (!reg_wready) begin @(negedge clk); #1; end
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ring(int g, logic [23:0] b, logic [23:0] e, logic [23:0] c);
    reg_write(ofs(g), 32'(b)); reg_write(ofs(g) + 8'd4, 32'(e)); reg_write(ofs(g) + 8'd8, 32'(c));
    m_base[g] = b; m_end[g] = e; m_cur[g] = c;
  endtask

  // driver: predict bursts from R4/R6/R7, then issue the request
  task automatic do_req(logic dir, int idx, int len, output logic hang);
    int g, d0, tmo;
    logic [23:0] p, sp, bl;
    int r;
    g = dir ? idx : 4 + idx;
    p = (m_cur[g] < m_base[g]) ? m_base[g] : m_cur[g];
    hang = (p >= m_end[g]);
    if (!hang) begin
      r = len;
      while (r > 0) begin
        burst_t b;
        sp = m_end[g] - p;
        bl = (sp < 24'(r)) ? sp : 24'(r);
        b.a = p; b.l = 16'(bl); b.w = dir;
        exp_q.push_back(b);
        p = p + bl;
        if (p == m_end[g]) p = m_base[g];
        r = r - int'(bl);
      end
      m_cur[g] = p;
    end
    d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_dir = dir; req_chan = 2'(idx); req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (hang) begin
      repeat (4) @(negedge clk);
      check("R5 no done on hang", 32'(done_cnt), 32'(d0));
    end else begin
      tmo = 0;
      while (done_cnt == d0 && tmo < 4000) begin @(negedge clk); tmo++; end
      check("R8 done seen", 32'(done_cnt), 32'(d0 + 1));
      check("R6 all bursts issued", 32'(exp_q.size()), 32'd0);
    end
  endtask

  task automatic check_cur(int g, string req);
    logic [31:0] v;
    reg_read(ofs(g) + 8'd8, v);
    check(req, v, 32'(m_cur[g]));
  endtask

  // monitor: pop expected bursts and acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        repeat (ack_dly) @(negedge clk);
        if (exp_q.size() == 0) begin
          check("R5 unexpected burst", 32'(mem_addr), 32'hFFFF_FFFF);
        end else begin
          burst_t b;
          b = exp_q.pop_front();
          check("R6 burst addr", 32'(mem_addr), 32'(b.a));
          check("R6 burst len", 32'(mem_len), 32'(b.l));
          check("R3 burst dir", 32'(mem_we), 32'(b.w));
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic hg;
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    reg_read(8'h00, v);        check("R1 status", v, 32'd0);
    reg_read(8'h2C, v);        check("R1 cur reg", v, 32'd0);
    reg_read(8'h68, v);        check("R1 end reg", v, 32'd0);
    check("R1 ready", 32'(req_ready), 32'd1);
    check("R1 mem_req", 32'(mem_req), 32'd0);

    // R2 masking
    reg_write(8'h64, 32'hFF12_3456); reg_read(8'h64, v); check("R2 bound mask", v, 32'h0012_3400);
    reg_write(8'h6C, 32'hFF00_00FF); reg_read(8'h6C, v); check("R2 ptr mask", v, 32'h0000_00FC);
    reg_write(8'h58, 32'hABCD_EFFF); reg_read(8'h58, v); check("R2 out3 end", v, 32'h00CD_EF00);

    // R6 R7 R8 R3: split at ring end on write ring 1
    set_ring(1, 24'h1000, 24'h1100, 24'h10F0);
    do_req(1'b1, 1, 'h40, hg);
    check_cur(1, "R8 writeback split");
    // R4 R3: read ring 0, pointer below base
    set_ring(4, 24'h2000, 24'h2200, 24'h1000);
    do_req(1'b0, 0, 'h20, hg);
    check_cur(4, "R4 clamp");
    // R7 exact wrap
    set_ring(3, 24'h3000, 24'h3100, 24'h30C0);
    do_req(1'b1, 3, 'h40, hg);
    check_cur(3, "R7 exact wrap");
    // R7 multiple wraps in one request
    ack_dly = 0;
    do_req(1'b1, 3, 'h250, hg);
    check_cur(3, "R7 multi wrap");
    // R9 zero length
    set_ring(5, 24'h4000, 24'h4100, 24'h0000);
    do_req(1'b0, 1, 0, hg);
    check_cur(5, "R9 zero length clamp");

    // R5 hang on write ring 2 and read ring 1
    set_ring(2, 24'h5000, 24'h5100, 24'h5200);
    do_req(1'b1, 2, 'h10, hg);
    check("R5 predicted hang", 32'(hg), 32'd1);
    set_ring(5, 24'h4100, 24'h4100, 24'h0000);
    do_req(1'b0, 1, 'h10, hg);
    reg_read(8'h00, v); check("R5 status bits", v, 32'h24);
    check_cur(2, "R5 ptr untouched");
    // R13
    reg_write(8'h00, 32'h04);
    reg_read(8'h00, v); check("R13 w1c", v, 32'h20);

    // R10 R12 hold-off
    set_ring(0, 24'h6000, 24'h6100, 24'h6000);
    ack_dly = 8;
    fork
      do_req(1'b1, 0, 'h80, hg);
      begin
        repeat (3) @(negedge clk);
        check("R12 ready low while busy", 32'(req_ready), 32'd0);
        reg_we = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h7000;
        #1 check("R10 busy ring held", 32'(reg_wready), 32'd0);
        reg_we = 1'b0;
        d0 = done_cnt;
        reg_write(8'h38, 32'h1200);
        check("R10 other ring free", 32'(done_cnt), 32'(d0));
        m_end[1] = 24'h1200;
        reg_write(8'h24, 32'h7000);
        check("R10 write after done", 32'(done_cnt), 32'(d0 + 1));
        m_base[0] = 24'h7000;
      end
    join
    check_cur(0, "R8 cur after held write");
    reg_read(8'h24, v); check("R10 held write landed", v, 32'h7000);
    reg_read(8'h38, v); check("R10 other write landed", v, 32'h1200);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule